// File: doc/BRIEF.md
# Manchester II Word Receiver

This block decodes one channel of a bi-phase (Manchester II) serial bus into 16-bit words. A comparator stage outside the block turns the differential line into two digital levels: a positive indicator and a negative indicator. When exactly one of them is high the line carries a level. When neither or both are high the line is quiet. The block runs at twelve clocks per bit. It recognises a word sync, tells a command sync from a data sync, samples the two half-bit cells of each of the 17 following bits (16 data bits then parity), and checks the half-cell coding, the bit count and odd parity.

When a word is good, the data lands in a holding register, the sync type is stored and a word-ready flag rises. When a word is bad, a sticky error flag rises instead. A host clears the ready flag with a read strobe; the arrival of the next sync also clears it. An idle indicator shows when the bus has been quiet for a while. An enable input makes the channel ignore everything on the line. A dual-bus system places two of these blocks side by side.

Top module: `manchester_rx`

## Requirements
- R1: A sync is accepted only when the line holds one level for 16 to 20 clocks and then switches to the opposite level. If the first level is positive, `rx_cmd` becomes 1 (command word). If it is negative, `rx_cmd` becomes 0 (data word). A first level that lasts 10 clocks starts no word.
- R2: Data bits arrive most significant first. A one is positive in the first half-bit and negative in the second; a zero is the reverse. A good word is loaded into `rx_word`.
- R3: The 17th bit is parity. The count of ones over the 16 data bits plus parity must be odd. A parity failure sets `err_flag` and leaves `word_rdy` low.
- R4: A bit whose two half-cells carry the same level is a coding error. It sets `err_flag`, does not raise `word_rdy`, and leaves `rx_word` unchanged.
- R5: A word that goes quiet before all 17 bits are complete is an error and sets `err_flag`.
- R6: `word_rdy` rises only after the parity bit has been sampled. It is still low at the start of the parity bit and is high within four clocks after the last parity half-cell.
- R7: A pulse on `rd_stb` clears `word_rdy`. It leaves `rx_word` and `rx_cmd` unchanged.
- R8: An accepted sync clears `word_rdy`, so the flag is low during the next word.
- R9: `err_flag` stays set until reset; `rd_stb` does not clear it.
- R10: `gap` is 0 out of reset, becomes 1 after 30 quiet clocks, and is 0 while a word is on the line.
- R11: While `rx_en` is 0, a complete frame on the line changes none of `word_rdy`, `rx_word` and `err_flag`, and `gap` reads 1 because the line is treated as quiet.
- R12: If `rd_stb` arrives in the same cycle in which a word completes, the new word wins and `word_rdy` ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, twelve per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Channel enable; 0 ignores the line |
| rx_pos | input | 1 | Positive-level comparator output |
| rx_neg | input | 1 | Negative-level comparator output |
| rd_stb | input | 1 | Host read of the word register; clears the ready flag |
| rx_word | output | 16 | Last good received word |
| rx_cmd | output | 1 | Sync type of the last good word (1 = command) |
| word_rdy | output | 1 | A new good word is waiting |
| err_flag | output | 1 | Sticky receive error |
| gap | output | 1 | Bus quiet indicator |

## Verification
Two events can fall in the same clock: a host read strobe and the completion of a word. They compete for the ready flag. The bench provokes the collision by raising `rd_stb` together with the final parity half-cell, which lines the strobe up with the clock in which the decoder finishes. It then requires the flag to read 1 afterwards. A second pairing, an accepted sync against a flag still set from the previous word, is checked by looking at the flag early in a back-to-back word.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } mrx_state_e;
endpackage

// File: rtl/mrx_front.sv
module mrx_front #(
  parameter int CLK_PER_BIT = 12,
  parameter int SYNC_TOL    = 2,
  parameter int GAP_CLKS    = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic rx_pos,
  input  logic rx_neg,
  input  logic busy,
  output logic act,
  output logic lvl,
  output logic start,
  output logic start_cmd,
  output logic gap
);
  localparam int SYNC    = (CLK_PER_BIT * 3) / 2;
  localparam int RUN_MAX = SYNC + SYNC_TOL + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int QW      = $clog2(GAP_CLKS + 1);
  localparam logic [RUN_W-1:0] RUN_LO  = RUN_W'(SYNC - SYNC_TOL);
  localparam logic [RUN_W-1:0] RUN_HI  = RUN_W'(SYNC + SYNC_TOL);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_MAX);
  localparam logic [QW-1:0]    Q_TOP   = QW'(GAP_CLKS);

  logic p1_q, n1_q, p2_q, n2_q;
  logic prev_act_q, prev_lvl_q;
  logic [RUN_W-1:0] run_q, run_d;
  logic [QW-1:0]    quiet_q, quiet_d;
  logic             edge_seen;

  always_comb begin
    act = rx_en & (p2_q ^ n2_q);
    lvl = p2_q;
    if (!act)
      run_d = '0;
    else if (prev_act_q && (lvl == prev_lvl_q))
      run_d = (run_q == RUN_TOP) ? run_q : run_q + 1'b1;
    else
      run_d = RUN_W'(1);
    quiet_d   = act ? '0 : ((quiet_q == Q_TOP) ? quiet_q : quiet_q + 1'b1);
    edge_seen = act & prev_act_q & (lvl != prev_lvl_q);
    start     = edge_seen & ~busy & (run_q >= RUN_LO) & (run_q <= RUN_HI);
    start_cmd = prev_lvl_q;
    gap       = (quiet_q == Q_TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_q <= 1'b0; n1_q <= 1'b0; p2_q <= 1'b0; n2_q <= 1'b0;
      prev_act_q <= 1'b0; prev_lvl_q <= 1'b0;
      run_q <= '0; quiet_q <= '0;
    end else begin
      p1_q <= rx_pos; n1_q <= rx_neg;
      p2_q <= p1_q;   n2_q <= n1_q;
      prev_act_q <= act;
      prev_lvl_q <= lvl;
      run_q      <= run_d;
      quiet_q    <= quiet_d;
    end
  end

  // R10
  gap_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap && act) |=> !gap);
endmodule

// File: rtl/mrx_bits.sv
module mrx_bits
  import mrx_pkg::*;
#(
  parameter int CLK_PER_BIT = 12,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              act,
  input  logic              lvl,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic [DATA_W-1:0] word
);
  localparam int SYNC = (CLK_PER_BIT * 3) / 2;
  localparam int PH_W = $clog2(SYNC);
  localparam int BI_W = $clog2(DATA_W + 1);
  localparam logic [PH_W-1:0] PH_SMID = PH_W'(SYNC / 2);
  localparam logic [PH_W-1:0] PH_SEND = PH_W'(SYNC - 1);
  localparam logic [PH_W-1:0] PH_Q1   = PH_W'(CLK_PER_BIT / 4);
  localparam logic [PH_W-1:0] PH_Q3   = PH_W'((CLK_PER_BIT * 3) / 4);
  localparam logic [PH_W-1:0] PH_BEND = PH_W'(CLK_PER_BIT - 1);
  localparam logic [BI_W-1:0] BI_PAR  = BI_W'(DATA_W);

  mrx_state_e st_q, st_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [BI_W-1:0]   bi_q, bi_d;
  logic              first_q, first_d, exp_q, exp_d;
  logic              par_q, par_d, bad_q, bad_d;
  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    st_d = st_q; ph_d = ph_q; bi_d = bi_q;
    first_d = first_q; exp_d = exp_q; par_d = par_q; bad_d = bad_q;
    sh_d = sh_q; done = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_SYNC; ph_d = PH_W'(1); bi_d = '0;
        exp_d = lvl; bad_d = 1'b0; par_d = 1'b0;
      end
      ST_SYNC: begin
        ph_d = ph_q + 1'b1;
        if ((ph_q == PH_SMID) && (!act || (lvl != exp_q))) bad_d = 1'b1;
        if (ph_q == PH_SEND) begin
          st_d = ST_DATA; ph_d = '0;
        end
      end
      ST_DATA: begin
        ph_d = (ph_q == PH_BEND) ? '0 : ph_q + 1'b1;
        if (ph_q == PH_BEND) bi_d = bi_q + 1'b1;
        if (ph_q == PH_Q1) begin
          first_d = lvl;
          if (!act) bad_d = 1'b1;
        end
        if (ph_q == PH_Q3) begin
          if (!act || (lvl == first_q)) bad_d = 1'b1;
          par_d = par_q ^ first_q;
          if (bi_q == BI_PAR) begin
            done = 1'b1; st_d = ST_IDLE;
          end else begin
            sh_d = {sh_q[DATA_W-2:0], first_q};
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (!rx_en) begin
      st_d = ST_IDLE; done = 1'b0;
    end
    ok   = ~bad_d & par_d;
    busy = (st_q != ST_IDLE);
    word = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; ph_q <= '0; bi_q <= '0;
      first_q <= 1'b0; exp_q <= 1'b0; par_q <= 1'b0; bad_q <= 1'b0;
      sh_q <= '0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; bi_q <= bi_d;
      first_q <= first_d; exp_q <= exp_d; par_q <= par_d; bad_q <= bad_d;
      sh_q <= sh_d;
    end
  end

  // R11
  dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !busy);
endmodule

// File: rtl/manchester_rx.sv
module manchester_rx #(
  parameter int CLK_PER_BIT = 12,
  parameter int SYNC_TOL    = 2,
  parameter int DATA_W      = 16,
  parameter int GAP_CLKS    = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_pos,
  input  logic              rx_neg,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_cmd,
  output logic              word_rdy,
  output logic              err_flag,
  output logic              gap
);
  logic act, lvl, start, start_cmd, busy, done, ok;
  logic [DATA_W-1:0] bits_word;
  logic [DATA_W-1:0] word_q, word_d;
  logic cmd_q, cmd_d, rdy_q, rdy_d, err_q, err_d, pend_q, pend_d;

  mrx_front #(.CLK_PER_BIT(CLK_PER_BIT), .SYNC_TOL(SYNC_TOL), .GAP_CLKS(GAP_CLKS)) u_front (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .busy(busy), .act(act), .lvl(lvl), .start(start), .start_cmd(start_cmd), .gap(gap)
  );

  mrx_bits #(.CLK_PER_BIT(CLK_PER_BIT), .DATA_W(DATA_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .act(act), .lvl(lvl), .start(start),
    .busy(busy), .done(done), .ok(ok), .word(bits_word)
  );

  always_comb begin
    word_d = word_q; cmd_d = cmd_q; rdy_d = rdy_q; err_d = err_q; pend_d = pend_q;
    if (start) begin
      pend_d = start_cmd; rdy_d = 1'b0;
    end
    if (rd_stb) rdy_d = 1'b0;
    if (done) begin
      if (ok) begin
        word_d = bits_word; cmd_d = pend_q; rdy_d = 1'b1;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0; cmd_q <= 1'b0; rdy_q <= 1'b0; err_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      word_q <= word_d; cmd_q <= cmd_d; rdy_q <= rdy_d; err_q <= err_d; pend_q <= pend_d;
    end
  end

  assign rx_word  = word_q;
  assign rx_cmd   = cmd_q;
  assign word_rdy = rdy_q;
  assign err_flag = err_q;

  // R4
  rdy_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(word_rdy) && $rose(err_flag)));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  // R2
  word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_word) |-> word_rdy);
  // R7
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_rdy && rd_stb && !done) |=> !word_rdy);
endmodule

// File: tb/sim_manchester_rx.sv
module sim_manchester_rx;
  logic clk, rst_n, rx_en, rx_pos, rx_neg, rd_stb;
  logic [15:0] rx_word;
  logic rx_cmd, word_rdy, err_flag, gap;
  int n_chk, n_bad;
  logic mid_rdy, par_rdy, mid_gap;

  manchester_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .rd_stb(rd_stb), .rx_word(rx_word), .rx_cmd(rx_cmd), .word_rdy(word_rdy),
    .err_flag(err_flag), .gap(gap)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic slot(input logic p, input logic n);
    @(negedge clk);
    rx_pos = p; rx_neg = n;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) slot(1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rx_en = 1'b1; rx_pos = 1'b0; rx_neg = 1'b0; rd_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic read_pulse();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  // one frame: sync, 16 bits MSB first, parity; optional faults
  task automatic send(input logic cmd, input logic [15:0] d, input int first_len,
                      input bit flip_par, input int bad_bit, input int nbits, input bit rd_last);
    logic par, b;
    par = ~(^d) ^ flip_par;
    for (int i = 0; i < first_len; i++) slot(cmd, ~cmd);
    for (int i = 0; i < 18; i++) begin
      if (i == 6) mid_rdy = word_rdy;
      slot(~cmd, cmd);
    end
    for (int i = 0; i < 17; i++) begin
      b = (i < 16) ? d[15-i] : par;
      if (i == 8) mid_gap = gap;
      if (i == 16) par_rdy = word_rdy;
      for (int h = 0; h < 12; h++) begin
        if (i >= nbits) slot(1'b0, 1'b0);
        else if (i == bad_bit) slot(1'b1, 1'b0);
        else if (h < 6) slot(b, ~b);
        else slot(~b, b);
        if (rd_last && i == 16 && h == 11) rd_stb = 1'b1;
      end
    end
    @(negedge clk);
    rd_stb = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 gap after reset", gap, 0);
    chk("R6 rdy after reset", word_rdy, 0);
    chk("R9 err after reset", err_flag, 0);
    chk("R2 word after reset", rx_word, 0);
    idle(40);
    chk("R10 gap quiet", gap, 1);
  endtask

  task automatic t_cmd_word();
    send(1'b1, 16'hA5C3, 18, 0, -1, 17, 0);
    chk("R6 rdy before parity", par_rdy, 0);
    chk("R10 gap during word", mid_gap, 0);
    idle(3);
    chk("R6 rdy after word", word_rdy, 1);
    chk("R2 cmd word data", rx_word, 16'hA5C3);
    chk("R1 command sync", rx_cmd, 1);
    chk("R3 good parity no err", err_flag, 0);
  endtask

  task automatic t_read();
    read_pulse();
    chk("R7 rdy cleared", word_rdy, 0);
    chk("R7 word kept", rx_word, 16'hA5C3);
    chk("R7 cmd kept", rx_cmd, 1);
  endtask

  task automatic t_data_word();
    send(1'b0, 16'h0001, 17, 0, -1, 17, 0);
    idle(3);
    chk("R1 data sync", rx_cmd, 0);
    chk("R2 data word", rx_word, 16'h0001);
    chk("R1 short tolerance rdy", word_rdy, 1);
  endtask

  task automatic t_back2back();
    send(1'b1, 16'h8000, 19, 0, -1, 17, 0);
    chk("R8 first rdy", word_rdy, 1);
    send(1'b0, 16'h7FFE, 18, 0, -1, 17, 0);
    chk("R8 rdy cleared by sync", mid_rdy, 0);
    idle(3);
    chk("R8 second word", rx_word, 16'h7FFE);
    chk("R8 rdy again", word_rdy, 1);
  endtask

  task automatic t_parity();
    do_reset();
    send(1'b1, 16'h1357, 18, 1, -1, 17, 0);
    idle(3);
    chk("R3 parity err", err_flag, 1);
    chk("R3 no rdy", word_rdy, 0);
    chk("R3 word untouched", rx_word, 0);
  endtask

  task automatic t_coding();
    do_reset();
    send(1'b0, 16'h2468, 18, 0, -1, 17, 0);
    idle(3);
    read_pulse();
    send(1'b0, 16'hFFFF, 18, 0, 5, 17, 0);
    idle(3);
    chk("R4 coding err", err_flag, 1);
    chk("R4 no rdy", word_rdy, 0);
    chk("R4 word kept", rx_word, 16'h2468);
    read_pulse();
    chk("R9 err survives read", err_flag, 1);
    idle(30);
    chk("R9 err still set", err_flag, 1);
  endtask

  task automatic t_trunc();
    do_reset();
    send(1'b1, 16'hC0DE, 18, 0, -1, 8, 0);
    idle(3);
    chk("R5 truncated err", err_flag, 1);
    chk("R5 truncated no rdy", word_rdy, 0);
  endtask

  task automatic t_badsync();
    do_reset();
    send(1'b1, 16'h1234, 10, 0, -1, 17, 0);
    idle(3);
    chk("R1 short sync no rdy", word_rdy, 0);
    chk("R1 short sync no err", err_flag, 0);
    chk("R1 short sync no word", rx_word, 0);
  endtask

  task automatic t_disable();
    do_reset();
    send(1'b1, 16'h0F0F, 18, 0, -1, 17, 0);
    idle(3);
    @(negedge clk); rx_en = 1'b0;
    send(1'b0, 16'h3C3C, 18, 0, -1, 17, 0);
    idle(3);
    chk("R11 rdy unchanged", word_rdy, 1);
    chk("R11 word unchanged", rx_word, 16'h0F0F);
    chk("R11 err unchanged", err_flag, 0);
    chk("R11 gap while off", gap, 1);
    @(negedge clk); rx_en = 1'b1;
    idle(5);
  endtask

  task automatic t_collide();
    do_reset();
    send(1'b0, 16'hBEEF, 18, 0, -1, 17, 1);
    chk("R12 set wins over read", word_rdy, 1);
    chk("R12 word", rx_word, 16'hBEEF);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    mid_rdy = 1'b0; par_rdy = 1'b0; mid_gap = 1'b0;
    rst_n = 1'b0; rx_en = 1'b1; rx_pos = 1'b0; rx_neg = 1'b0; rd_stb = 1'b0;
    t_reset();
    t_cmd_word();
    t_read();
    t_data_word();
    t_back2back();
    t_parity();
    t_coding();
    t_trunc();
    t_badsync();
    t_disable();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule